// File: doc/BRIEF.md
# Per-Bank Precharge and Activate Timing Guard

This block sits beside the command issue stage of a DRAM controller and tracks, bank by bank, when a PRECHARGE and an ACTIVATE may legally be sent. It watches each command as it goes out: the command type, the target bank, the burst length code and a truncation flag. From these it keeps two saturating down-counters per bank. One counts the remaining cycles before a PRECHARGE is allowed after a READ or WRITE. The other counts the remaining cycles before an ACTIVATE is allowed after a PRECHARGE.

The scheduler reads the per-bank `pre_ok_o` and `act_ok_o` flags to decide what it may issue. If a PRECHARGE or ACTIVATE reaches the block while its bank is still blocked, the block raises `violation_o` for one cycle and discards the command, so it changes no counter. The timing values are quasi-static inputs expressed in clock cycles, each already rounded up: write latency, write recovery, read-to-precharge and precharge period.

Top module: `prechg_act_guard`

## Requirements
- R1: After reset is released, every bit of `pre_ok_o` and `act_ok_o` is 1 and `violation_o` is 0.
- R2: Commands are coded on `cmd_i` as 0 no-op, 1 ACTIVATE, 2 READ, 3 WRITE and 4 PRECHARGE. A READ to bank b sampled at edge t makes PRECHARGE to b legal from edge t+`rtp_i`. `pre_ok_o[b]` is 0 after edge t and becomes 1 after edge t+max(`rtp_i`,1)-1.
- R3: A WRITE that is not truncated blocks PRECHARGE to its bank for `wl_i` + BL/2 + 1 + `twr_i` cycles, with BL taken from `mode_bl_i`.
- R4: A WRITE with `cmd_trunc_i`=1 uses the effective length from `cmd_bl_i` in place of the mode length.
- R5: Burst length codes: 1 means BL4, 2 means BL8, 3 means BL16, and code 0 is taken as BL4.
- R6: An accepted PRECHARGE to bank b at edge t makes ACTIVATE to b legal from edge t+`trp_i`. An ACTIVATE presented at that edge raises no violation.
- R7: A command to one bank changes no other bank's flags.
- R8: A later READ or WRITE to a bank that needs a shorter gap than the one still pending never shortens the pending gap. A longer gap replaces it.
- R9: A PRECHARGE to a bank whose `pre_ok_o` is 0, or an ACTIVATE to a bank whose `act_ok_o` is 0, sets `violation_o` to 1 for exactly the cycle after the offending edge. The rejected command has no effect on any flag.
- R10: READ, WRITE and no-op commands never raise `violation_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_i | input | 3 | Issued command code |
| cmd_bank_i | input | BANK_W | Target bank |
| cmd_trunc_i | input | 1 | Burst is truncated |
| cmd_bl_i | input | 2 | Effective burst length code, used when truncated |
| mode_bl_i | input | 2 | Mode burst length code |
| wl_i | input | TW | Write latency, cycles |
| twr_i | input | TW | Write recovery, cycles (rounded up) |
| rtp_i | input | TW | Read-to-precharge, cycles (rounded up) |
| trp_i | input | TW | Precharge period, cycles (rounded up) |
| pre_ok_o | output | NUM_BANKS | PRECHARGE allowed per bank |
| act_ok_o | output | NUM_BANKS | ACTIVATE allowed per bank |
| violation_o | output | 1 | One-cycle pulse after an illegal command |

## Verification
A wrong counter value shows up at the ports as a ready flag that changes on the wrong cycle. Each gap is therefore measured by counting the cycles from the command until the flag rises, and the result is compared with the formula. The exact legal edge is also probed: a PRECHARGE or ACTIVATE sent one edge too early must produce a violation pulse on the very next cycle, and one sent on time must not. Corruption that leaks across banks, or a rejected command that still loads a counter, shows as a flag dropping where it should stay high. These cases are checked right after the stimulus.

// File: rtl/prechg_guard_pkg.sv
package prechg_guard_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  // burst length code -> BL/2
  function automatic logic [3:0] half_bl(input logic [1:0] code);
    case (code)
      2'd2:    half_bl = 4'd4;
      2'd3:    half_bl = 4'd8;
      default: half_bl = 4'd2;
    endcase
  endfunction
endpackage

// File: rtl/prechg_gap_calc.sv
module prechg_gap_calc
  import prechg_guard_pkg::*;
#(
  parameter int TW = 4,
  parameter int CW = 6
) (
  input  logic          is_wr_i,
  input  logic          trunc_i,
  input  logic [1:0]    cmd_bl_i,
  input  logic [1:0]    mode_bl_i,
  input  logic [TW-1:0] wl_i,
  input  logic [TW-1:0] twr_i,
  input  logic [TW-1:0] rtp_i,
  output logic [CW-1:0] gap_o
);
  logic [1:0]    bl_code;
  logic [CW-1:0] wr_gap;

  assign bl_code = trunc_i ? cmd_bl_i : mode_bl_i;
  // prefetch group must be latched before recovery starts: +1
  assign wr_gap  = CW'(wl_i) + CW'(half_bl(bl_code)) + CW'(1) + CW'(twr_i);
  assign gap_o   = is_wr_i ? wr_gap : CW'(rtp_i);
endmodule

// File: rtl/prechg_bank_timer.sv
module prechg_bank_timer #(
  parameter int CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pre_load_i,
  input  logic [CW-1:0] pre_gap_i,
  input  logic          act_load_i,
  input  logic [CW-1:0] act_gap_i,
  output logic          pre_ok_o,
  output logic          act_ok_o
);
  logic [CW-1:0] pre_q, pre_d, act_q, act_d;

  function automatic logic [CW-1:0] next_cnt(input logic [CW-1:0] cur,
                                             input logic          ld,
                                             input logic [CW-1:0] gap);
    logic [CW-1:0] dec, tgt;
    dec = (cur != '0) ? cur - 1'b1 : '0;
    tgt = (gap != '0) ? gap - 1'b1 : '0;
    next_cnt = (ld && tgt > dec) ? tgt : dec;
  endfunction

  always_comb begin
    pre_d = next_cnt(pre_q, pre_load_i, pre_gap_i);
    act_d = next_cnt(act_q, act_load_i, act_gap_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      act_q <= '0;
    end else begin
      pre_q <= pre_d;
      act_q <= act_d;
    end
  end

  assign pre_ok_o = (pre_q == '0);
  assign act_ok_o = (act_q == '0);

  assert_rw_blocks_pre_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_load_i && pre_gap_i > CW'(1)) |=> !pre_ok_o);

  assert_pre_blocks_act_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_load_i && act_gap_i > CW'(1)) |=> !act_ok_o);

  assert_no_shorten_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_load_i && pre_q != '0) |=> pre_q >= $past(pre_q) - 1'b1);

  assert_sat_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pre_load_i && pre_ok_o) |=> pre_ok_o);
endmodule

// File: rtl/prechg_act_guard.sv
module prechg_act_guard
  import prechg_guard_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int TW        = 4,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int CW       = $clog2(3 * ((1 << TW) - 1) + 10)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [2:0]           cmd_i,
  input  logic [BANK_W-1:0]    cmd_bank_i,
  input  logic                 cmd_trunc_i,
  input  logic [1:0]           cmd_bl_i,
  input  logic [1:0]           mode_bl_i,
  input  logic [TW-1:0]        wl_i,
  input  logic [TW-1:0]        twr_i,
  input  logic [TW-1:0]        rtp_i,
  input  logic [TW-1:0]        trp_i,
  output logic [NUM_BANKS-1:0] pre_ok_o,
  output logic [NUM_BANKS-1:0] act_ok_o,
  output logic                 violation_o
);
  logic          is_rd, is_wr, is_pre, is_act;
  logic          pre_bad, act_bad, pre_acc;
  logic [CW-1:0] rw_gap, trp_gap;
  logic          viol_q;

  assign is_rd  = (cmd_i == CMD_RD);
  assign is_wr  = (cmd_i == CMD_WR);
  assign is_pre = (cmd_i == CMD_PRE);
  assign is_act = (cmd_i == CMD_ACT);

  assign pre_bad = is_pre && !pre_ok_o[cmd_bank_i];
  assign act_bad = is_act && !act_ok_o[cmd_bank_i];
  assign pre_acc = is_pre && !pre_bad;
  assign trp_gap = CW'(trp_i);

  prechg_gap_calc #(.TW(TW), .CW(CW)) u_gap (
    .is_wr_i   (is_wr),
    .trunc_i   (cmd_trunc_i),
    .cmd_bl_i  (cmd_bl_i),
    .mode_bl_i (mode_bl_i),
    .wl_i      (wl_i),
    .twr_i     (twr_i),
    .rtp_i     (rtp_i),
    .gap_o     (rw_gap)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (cmd_bank_i == BANK_W'(b));
    prechg_bank_timer #(.CW(CW)) u_tmr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pre_load_i (hit && (is_rd || is_wr)),
      .pre_gap_i  (rw_gap),
      .act_load_i (hit && pre_acc),
      .act_gap_i  (trp_gap),
      .pre_ok_o   (pre_ok_o[b]),
      .act_ok_o   (act_ok_o[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) viol_q <= 1'b0;
    else         viol_q <= pre_bad || act_bad;
  end

  assign violation_o = viol_q;

  assert_viol_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    violation_o |-> $past(cmd_i == CMD_PRE || cmd_i == CMD_ACT));

  assert_rw_no_viol_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_RD || cmd_i == CMD_WR || cmd_i == CMD_NOP) |=> !violation_o);

  assert_reject_keeps_act_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_PRE && !pre_ok_o[cmd_bank_i] && act_ok_o[cmd_bank_i])
      |=> act_ok_o[$past(cmd_bank_i)]);
endmodule

// File: tb/prechg_act_guard_test.sv
module prechg_act_guard_test;
  import prechg_guard_pkg::*;
  localparam int NB = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    cmd;
  logic [2:0]    bank;
  logic          trunc;
  logic [1:0]    cbl, mbl;
  logic [3:0]    wl, twr, rtp, trp;
  logic [NB-1:0] pre_ok, act_ok;
  logic          viol;
  int            checks = 0, errors = 0;

  always #4 clk = ~clk;

  prechg_act_guard #(.NUM_BANKS(NB), .TW(4)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .cmd_bank_i(bank),
    .cmd_trunc_i(trunc), .cmd_bl_i(cbl), .mode_bl_i(mbl),
    .wl_i(wl), .twr_i(twr), .rtp_i(rtp), .trp_i(trp),
    .pre_ok_o(pre_ok), .act_ok_o(act_ok), .violation_o(viol)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive at negedge, command sampled at next posedge, return at following negedge
  task automatic issue(input logic [2:0] c, input int b, input logic tr, input logic [1:0] bl);
    cmd = c; bank = 3'(b); trunc = tr; cbl = bl;
    @(negedge clk);
    cmd = CMD_NOP; trunc = 1'b0;
  endtask

  task automatic wait_pre(input int b, output int n);
    n = 1;
    while (!pre_ok[b] && n < 80) begin @(negedge clk); n++; end
  endtask

  task automatic wait_act(input int b, output int n);
    n = 1;
    while (!act_ok[b] && n < 80) begin @(negedge clk); n++; end
  endtask

  task automatic drain();
    repeat (50) @(negedge clk);
  endtask

  task automatic t_reset();
    check(pre_ok == '1, "R1 pre_ok", int'(pre_ok), 255);
    check(act_ok == '1, "R1 act_ok", int'(act_ok), 255);
    check(viol == 1'b0, "R1 violation", int'(viol), 0);
  endtask

  task automatic t_read();
    int n;
    issue(CMD_RD, 1, 0, 0);
    check(viol == 0, "R10 read no violation", int'(viol), 0);
    wait_pre(1, n);
    check(n == 3, "R2 read gap rtp=3", n, 3);
    rtp = 4'd1; drain();
    issue(CMD_RD, 1, 0, 0); wait_pre(1, n);
    check(n == 1, "R2 read gap rtp=1", n, 1);
    rtp = 4'd3; drain();
  endtask

  task automatic t_write_full();
    int n;
    issue(CMD_WR, 2, 0, 0);
    check(viol == 0, "R10 write no violation", int'(viol), 0);
    wait_pre(2, n);
    check(n == 12, "R3 write gap BL8", n, 12);
    drain();
    mbl = 2'd3;
    issue(CMD_WR, 2, 0, 0); wait_pre(2, n);
    check(n == 16, "R3 R5 write gap BL16", n, 16);
    mbl = 2'd2; drain();
  endtask

  task automatic t_write_trunc();
    int n;
    issue(CMD_WR, 5, 1, 2'd1); wait_pre(5, n);
    check(n == 10, "R4 truncated BL4", n, 10);
    drain();
    issue(CMD_WR, 5, 1, 2'd0); wait_pre(5, n);
    check(n == 10, "R5 code0 as BL4", n, 10);
    drain();
  endtask

  task automatic t_ref_seq();
    int n;
    issue(CMD_RD, 3, 0, 0);
    @(negedge clk);
    issue(CMD_PRE, 3, 0, 0);  // edge t+2: too early
    check(viol == 1, "R9 early precharge", int'(viol), 1);
    check(act_ok[3] == 1, "R9 rejected precharge no effect", int'(act_ok[3]), 1);
    issue(CMD_PRE, 3, 0, 0);  // edge t+3: legal
    check(viol == 0, "R2 precharge at rtp", int'(viol), 0);
    check(act_ok[3] == 0, "R6 act blocked", int'(act_ok[3]), 0);
    @(negedge clk);
    issue(CMD_ACT, 3, 0, 0);  // edge +2: too early
    check(viol == 1, "R9 early activate", int'(viol), 1);
    issue(CMD_ACT, 3, 0, 0);  // edge +3: legal
    check(viol == 0, "R6 activate at trp", int'(viol), 0);
    drain();
    issue(CMD_PRE, 6, 0, 0); wait_act(6, n);
    check(n == 3, "R6 act wait", n, 3);
    drain();
  endtask

  task automatic t_viol_pulse();
    issue(CMD_WR, 4, 0, 0);
    issue(CMD_PRE, 4, 0, 0);
    check(viol == 1, "R9 pulse high", int'(viol), 1);
    @(negedge clk);
    check(viol == 0, "R9 pulse one cycle", int'(viol), 0);
    check(act_ok[4] == 1, "R9 rejected no act block", int'(act_ok[4]), 1);
    drain();
  endtask

  task automatic t_indep();
    issue(CMD_WR, 0, 0, 0);
    check(pre_ok == 8'hFE, "R7 only bank0 blocked", int'(pre_ok), 254);
    check(act_ok == 8'hFF, "R7 act untouched", int'(act_ok), 255);
    issue(CMD_PRE, 7, 0, 0);
    check(act_ok == 8'h7F, "R7 only bank7 act blocked", int'(act_ok), 127);
    check(pre_ok == 8'hFE, "R7 pre flags unchanged", int'(pre_ok), 254);
    drain();
  endtask

  task automatic t_no_shorten();
    int n;
    issue(CMD_WR, 1, 0, 0);
    issue(CMD_RD, 1, 0, 0);
    wait_pre(1, n);
    check(n == 11, "R8 read keeps write gap", n, 11);
    drain();
    issue(CMD_RD, 1, 0, 0);
    issue(CMD_WR, 1, 0, 0);
    wait_pre(1, n);
    check(n == 12, "R8 write extends read gap", n, 12);
    drain();
  endtask

  initial begin
    #1200000;
    checks++; errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cmd = CMD_NOP; bank = '0; trunc = 0; cbl = 0; mbl = 2'd2;
    wl = 4'd3; twr = 4'd4; rtp = 4'd3; trp = 4'd3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read();
    t_write_full();
    t_write_trunc();
    t_ref_seq();
    t_viol_pulse();
    t_indep();
    t_no_shorten();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule